// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address. It reads a radix-tree page table that lives in memory. A requester supplies the physical base of the top-level table and the virtual address. The walker then reads one 64-bit table entry per level through a plain request/response memory port and never has more than one read in flight. Each level is indexed by its own 9-bit slice of the address, with the most significant slice used first. An ordinary walk ends at the fourth level with a 4 KB frame. A third-level entry marked as a large page ends the walk early with a 2 MB frame.

Each entry on the path must be present. Otherwise the walk stops and reports a page fault together with the level that failed. Any entry on the path can forbid execution, and the walker combines these marks into one execute-permitted flag. A result stays on the outputs, marked by a single-cycle done pulse, until the next request is accepted.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `done`, `fault`, `mem_req_valid`, `pa` and `exec_ok` are 0.
- R2: The level-L entry (L = 1..4) is read at table base + 8 × index. The index is va[47:39] for L=1, va[38:30] for L=2, va[29:21] for L=3 and va[20:12] for L=4. The level-1 base is `req_root` with its low 12 bits cleared. Each later base is entry bits 51:12 followed by 12 zero bits, so every read address has its low three bits at 0.
- R3: Only one memory read is outstanding at a time: `mem_req_valid` is not raised again until `mem_rsp_valid` has returned the previous entry.
- R4: When all four entries are present, the walk makes exactly four reads and returns pa = {leaf[51:12], va[11:0]}.
- R5: When the level-3 entry has bit 0 and bit 7 both set, the walk stops after three reads and returns pa = {entry[51:21], va[20:0]}.
- R6: Bit 7 has no effect in level-1, level-2 and level-4 entries. Those entries are treated as pointers or as a 4 KB leaf.
- R7: `exec_ok` is 0 when bit 63 is set in any entry read on the walk, and 1 otherwise.
- R8: An entry with bit 0 clear at level L stops the walk with no further reads. The walker then reports `fault`=1, `fault_level`=L (1..4), `pa`=0 and `exec_ok`=0. A successful walk reports `fault`=0 and `fault_level`=0.
- R9: Bits 63:48 of the virtual address have no effect on reads or results.
- R10: `req_ready` is 1 only while idle. A `req_valid` seen while a walk is in progress is ignored.
- R11: `done` is high for exactly one cycle per walk. `pa`, `exec_ok`, `fault` and `fault_level` change only in the cycle `done` rises, and they hold until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_root | input | 52 | Physical base of the level-1 table |
| req_va | input | 64 | Virtual address to translate |
| mem_req_valid | output | 1 | Entry read request (one cycle) |
| mem_req_addr | output | 52 | Physical address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Entry read from memory |
| done | output | 1 | One-cycle pulse: result ready |
| fault | output | 1 | Walk hit a non-present entry |
| fault_level | output | 3 | Level of the non-present entry, 0 when no fault |
| pa | output | 52 | Translated physical address |
| exec_ok | output | 1 | Execution permitted on the final page |

## Verification
A wrong level counter or a wrong index slice is visible on the very next `mem_req_addr`. The bench's memory model then returns a different or empty entry, so the damage shows up as a wrong `pa` or a false fault at the end of that walk. A no-execute accumulator that is lost or not cleared between walks shows up only in `exec_ok` at the `done` pulse, which is why walks with the mark at the first and at the last level run back to back. A broken early-stop test changes the read count by one and the frame bits of `pa` in the same walk.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int VA_W    = 64;
  localparam int PA_W    = 52;
  localparam int ENT_W   = 64;
  localparam int IDX_W   = 9;
  localparam int LEVELS  = 4;
  localparam int PG_SH   = 12;
  localparam int BIG_SH  = PG_SH + IDX_W;
  localparam int LVL_W   = $clog2(LEVELS);
  localparam int USED_W  = PG_SH + IDX_W * LEVELS;

  // entry field positions
  localparam int P_BIT   = 0;
  localparam int LG_BIT  = 7;
  localparam int NX_BIT  = 63;
  localparam int FR_LO   = 12;
  localparam int FR_HI   = 51;

  typedef logic [PA_W-1:0]  pa_t;
  typedef logic [ENT_W-1:0] ent_t;
  typedef logic [VA_W-1:0]  va_t;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WAIT} walk_st_e;

  function automatic pa_t slot_addr(pa_t base, logic [IDX_W-1:0] idx);
    return base + pa_t'({idx, 3'b000});
  endfunction

  function automatic pa_t frame_of(ent_t e);
    return {e[FR_HI:FR_LO], {PG_SH{1'b0}}};
  endfunction

  function automatic pa_t small_pa(ent_t e, va_t va);
    return {e[FR_HI:FR_LO], va[PG_SH-1:0]};
  endfunction

  function automatic pa_t big_pa(ent_t e, va_t va);
    return {e[FR_HI:BIG_SH], va[BIG_SH-1:0]};
  endfunction
endpackage

// File: rtl/pt_level_index.sv
module pt_level_index #(
  parameter int IDX_W  = 9,
  parameter int LEVELS = 4,
  parameter int LVL_W  = 2,
  localparam int FLD_W = IDX_W * LEVELS
) (
  input  logic [FLD_W-1:0] idx_field,
  input  logic [LVL_W-1:0] lvl,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] slice [LEVELS];

  // level 0 takes the most significant slice
  for (genvar l = 0; l < LEVELS; l++) begin : g_slice
    assign slice[l] = idx_field[IDX_W*(LEVELS-1-l) +: IDX_W];
  end

  always_comb idx = slice[lvl];
endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check
  import pt_walker_pkg::*;
#(
  parameter int BIG_LVL  = 2,
  parameter int LAST_LVL = 3
) (
  input  ent_t             ent,
  input  logic [LVL_W-1:0] lvl,
  output logic             present,
  output logic             no_exec,
  output logic             is_big,
  output logic             is_leaf,
  output pa_t              next_base
);
  logic unused_ent;
  assign unused_ent = ^{ent[62:52], ent[11:8], ent[6:1]};

  always_comb begin
    present   = ent[P_BIT];
    no_exec   = ent[NX_BIT];
    is_big    = ent[LG_BIT] && (lvl == LVL_W'(BIG_LVL));
    is_leaf   = (lvl == LVL_W'(LAST_LVL));
    next_base = frame_of(ent);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int N_LEVELS = LEVELS,
  parameter int IX_W     = IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PA_W-1:0]   req_root,
  input  logic [VA_W-1:0]   req_va,
  output logic              mem_req_valid,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ENT_W-1:0]  mem_rsp_data,
  output logic              done,
  output logic              fault,
  output logic [2:0]        fault_level,
  output logic [PA_W-1:0]   pa,
  output logic              exec_ok
);
  localparam int FLD_W = IX_W * N_LEVELS;

  walk_st_e          st_q;
  logic [LVL_W-1:0]  lvl_q;
  pa_t               base_q;
  logic [USED_W-1:0] va_q;
  logic              nx_q;

  logic unused_in;
  assign unused_in = ^{req_va[VA_W-1:USED_W], req_root[PG_SH-1:0]};

  // named events for the checker
  logic accept, rsp_take, walk_fault, walk_big, walk_leaf, walk_step, walk_end;
  logic [IX_W-1:0] cur_idx;
  logic ent_present, ent_nx, ent_big, ent_leaf;
  pa_t  ent_next;
  va_t  va_ext;

  pt_level_index #(.IDX_W(IX_W), .LEVELS(N_LEVELS), .LVL_W(LVL_W)) u_idx (
    .idx_field (va_q[PG_SH +: FLD_W]),
    .lvl       (lvl_q),
    .idx       (cur_idx)
  );

  pt_entry_check #(.BIG_LVL(N_LEVELS-2), .LAST_LVL(N_LEVELS-1)) u_ent (
    .ent       (mem_rsp_data),
    .lvl       (lvl_q),
    .present   (ent_present),
    .no_exec   (ent_nx),
    .is_big    (ent_big),
    .is_leaf   (ent_leaf),
    .next_base (ent_next)
  );

  assign va_ext        = {{(VA_W-USED_W){1'b0}}, va_q};
  assign req_ready     = (st_q == ST_IDLE);
  assign accept        = req_valid && req_ready;
  assign mem_req_valid = (st_q == ST_READ);
  assign mem_req_addr  = slot_addr(base_q, cur_idx);
  assign rsp_take      = (st_q == ST_WAIT) && mem_rsp_valid;
  assign walk_fault    = rsp_take && !ent_present;
  assign walk_big      = rsp_take && ent_present && ent_big;
  assign walk_leaf     = rsp_take && ent_present && ent_leaf && !ent_big;
  assign walk_step     = rsp_take && ent_present && !ent_big && !ent_leaf;
  assign walk_end      = walk_fault || walk_big || walk_leaf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      lvl_q       <= '0;
      base_q      <= '0;
      va_q        <= '0;
      nx_q        <= 1'b0;
      done        <= 1'b0;
      fault       <= 1'b0;
      fault_level <= '0;
      pa          <= '0;
      exec_ok     <= 1'b0;
    end else begin
      done <= walk_end;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          va_q   <= req_va[USED_W-1:0];
          base_q <= {req_root[PA_W-1:PG_SH], {PG_SH{1'b0}}};
          lvl_q  <= '0;
          nx_q   <= 1'b0;
          st_q   <= ST_READ;
        end
        ST_READ: st_q <= ST_WAIT;
        ST_WAIT: begin
          if (walk_fault) begin
            fault       <= 1'b1;
            fault_level <= {1'b0, lvl_q} + 3'd1;
            pa          <= '0;
            exec_ok     <= 1'b0;
            st_q        <= ST_IDLE;
          end else if (walk_big || walk_leaf) begin
            fault       <= 1'b0;
            fault_level <= '0;
            pa          <= walk_big ? big_pa(mem_rsp_data, va_ext)
                                    : small_pa(mem_rsp_data, va_ext);
            exec_ok     <= !(nx_q || ent_nx);
            st_q        <= ST_IDLE;
          end else if (walk_step) begin
            base_q <= ent_next;
            lvl_q  <= lvl_q + 1'b1;
            nx_q   <= nx_q || ent_nx;
            st_q   <= ST_READ;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_req_valid,
  input logic [2:0]        addr_lo,
  input logic              mem_rsp_valid,
  input logic              done,
  input logic              fault,
  input logic [2:0]        fault_level,
  input logic [51:0]       pa,
  input logic              exec_ok,
  input logic              walk_end
);
  logic inflight_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             inflight_q <= 1'b0;
    else if (mem_req_valid) inflight_q <= 1'b1;
    else if (mem_rsp_valid) inflight_q <= 1'b0;
  end

  AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !inflight_q);                                  // R3
  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (addr_lo == 3'b000));                          // R2
  AST_FAULT_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (fault_level != 3'd0 && fault_level <= 3'd4)); // R8
  AST_STOP_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    walk_end |=> !mem_req_valid);                                    // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);                                   // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                 // R11
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(pa) && $stable(fault) && $stable(exec_ok) && $stable(fault_level))); // R11
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .addr_lo       (mem_req_addr[2:0]),
  .mem_rsp_valid (mem_rsp_valid),
  .done          (done),
  .fault         (fault),
  .fault_level   (fault_level),
  .pa            (pa),
  .exec_ok       (exec_ok),
  .walk_end      (walk_end)
);

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [51:0] req_root = '0;
  logic [63:0] req_va = '0;
  logic        mem_req_valid;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done, fault, exec_ok;
  logic [2:0]  fault_level;
  logic [51:0] pa;

  always #2 clk = ~clk;

  pt_walker uut (.*);

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // memory model
  logic [63:0] pt_mem [logic [51:0]];
  localparam logic [63:0] NX = 64'h8000_0000_0000_0000;

  function automatic logic [63:0] rd(logic [51:0] a);
    return pt_mem.exists(a) ? pt_mem[a] : 64'h0;
  endfunction

  function automatic logic [63:0] mkva(int i1, int i2, int i3, int i4, int off, int hi);
    logic [63:0] v;
    v = (64'(hi & 16'hFFFF) << 48) | (64'(i1) << 39) | (64'(i2) << 30)
      | (64'(i3) << 21) | (64'(i4) << 12) | 64'(off & 12'hFFF);
    return v;
  endfunction

  typedef struct {
    logic [51:0] pa;
    logic        ex;
    logic        flt;
    logic [2:0]  lvl;
    int          reads;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  function automatic exp_t exp_walk(logic [51:0] root, logic [63:0] va, string tag);
    exp_t r;
    logic [51:0] base;
    logic [63:0] e;
    logic nx;
    r.pa = '0; r.ex = 1'b0; r.flt = 1'b0; r.lvl = '0; r.reads = 0; r.tag = tag;
    base = root & ~52'hFFF;
    nx = 1'b0;
    for (int l = 1; l <= 4; l++) begin
      int idx;
      idx = int'((va >> (39 - 9 * (l - 1))) & 64'h1FF);
      e = rd(base + 52'(idx * 8));
      r.reads++;
      if (e[0] == 1'b0) begin r.flt = 1'b1; r.lvl = 3'(l); return r; end
      nx = nx | e[63];
      if (l == 3 && e[7]) begin
        r.pa = 52'((e & 64'h000F_FFFF_FFE0_0000) | (va & 64'h1F_FFFF));
        r.ex = !nx; return r;
      end
      if (l == 4) begin
        r.pa = 52'((e & 64'h000F_FFFF_FFFF_F000) | (va & 64'hFFF));
        r.ex = !nx; return r;
      end
      base = 52'(e & 64'h000F_FFFF_FFFF_F000);
    end
    return r;
  endfunction

  // memory responder and result monitor
  logic        pend = 1'b0;
  logic        rsp_busy = 1'b0;
  logic [51:0] pend_addr = '0;
  int          reads_seen = 0;
  logic [51:0] last_pa = '0;

  always @(negedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (rst_n) begin
      if (pend) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= rd(pend_addr);
        pend = 1'b0;
        rsp_busy = 1'b0;
      end
      if (mem_req_valid) begin
        chk(!rsp_busy, "R3", "read issued while one outstanding", 64'(rsp_busy), 64'd0);
        pend = 1'b1;
        rsp_busy = 1'b1;
        pend_addr = mem_req_addr;
        reads_seen++;
      end
      if (done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10", "unexpected done pulse", 64'd1, 64'd0);
        end else begin
          exp_t x;
          x = exp_q.pop_front();
          chk(pa == x.pa, x.tag, "pa", 64'(pa), 64'(x.pa));
          chk(exec_ok == x.ex, x.tag, "exec_ok", 64'(exec_ok), 64'(x.ex));
          chk(fault == x.flt, x.tag, "fault", 64'(fault), 64'(x.flt));
          chk(fault_level == x.lvl, x.tag, "fault_level", 64'(fault_level), 64'(x.lvl));
          chk(reads_seen == x.reads, x.tag, "read count", 64'(reads_seen), 64'(x.reads));
          last_pa = x.pa;
        end
        reads_seen = 0;
      end
    end
  end

  task automatic start(input logic [51:0] root, input logic [63:0] va);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_root = root; req_va = va;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_walk();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic walk(input logic [51:0] root, input logic [63:0] va, input string tag);
    exp_q.push_back(exp_walk(root, va, tag));
    start(root, va);
    finish_walk();
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    // table images
    pt_mem[52'h1000 + 1*8]  = 64'h2000 | 1;
    pt_mem[52'h2000 + 2*8]  = 64'h3000 | 1;
    pt_mem[52'h3000 + 3*8]  = 64'h4000 | 1;
    pt_mem[52'h4000 + 4*8]  = 64'h1234_5000 | 1;
    pt_mem[52'h1000 + 5*8]  = NX | 64'h2000 | 1;
    pt_mem[52'h4000 + 6*8]  = NX | 64'h0ABC_D000 | 1;
    pt_mem[52'h3000 + 7*8]  = 64'h4_0020_0000 | 64'h81;
    pt_mem[52'h2000 + 8*8]  = 64'h3000 | 64'h81;
    pt_mem[52'h4000 + 9*8]  = 64'h5555_5000 | 64'h81;
    pt_mem[52'h1000 + 10*8] = 64'h2000 | 64'h81;
    pt_mem[52'h3000 + 11*8] = NX | 64'h60_0000 | 64'h81;
    pt_mem[52'h4000 + 51*8] = 64'h7777_7000;
    pt_mem[52'h9000 + 1*8]  = 64'h2000 | 1;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "req_ready in reset", 64'(req_ready), 64'd1);
    chk(done == 1'b0, "R1", "done in reset", 64'(done), 64'd0);
    chk(mem_req_valid == 1'b0, "R1", "mem_req_valid in reset", 64'(mem_req_valid), 64'd0);
    chk(fault == 1'b0 && pa == '0 && exec_ok == 1'b0, "R1", "results in reset",
        64'(pa), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    walk(52'h1000, mkva(1, 2, 3, 4, 12'hABC, 0), "R4");        // R2 R4 full walk
    walk(52'h1000, mkva(1, 2, 3, 4, 12'h123, 16'hFFFF), "R9"); // upper bits ignored
    walk(52'h1000, mkva(1, 2, 3, 4, 12'h123, 16'hA5A5), "R9");
    walk(52'h1FFF, mkva(1, 2, 3, 4, 12'h7, 0), "R2");          // root low bits cleared
    walk(52'h9000, mkva(1, 2, 3, 4, 12'hFFF, 0), "R2");        // other root
    walk(52'h1000, mkva(5, 2, 3, 4, 12'h10, 0), "R7");         // nx at level 1
    walk(52'h1000, mkva(1, 2, 3, 4, 12'h10, 0), "R7");         // accumulator cleared
    walk(52'h1000, mkva(1, 2, 3, 6, 12'h20, 0), "R7");         // nx at leaf
    walk(52'h1000, mkva(1, 2, 7, 9'h155, 12'hABC, 0), "R5");   // 2 MB page
    walk(52'h1000, mkva(1, 2, 11, 9'h1FF, 12'hFFF, 0), "R5");  // 2 MB with nx
    walk(52'h1000, mkva(1, 8, 3, 4, 12'h44, 0), "R6");         // large bit level 2
    walk(52'h1000, mkva(1, 2, 3, 9, 12'h55, 0), "R6");         // large bit level 4
    walk(52'h1000, mkva(10, 2, 3, 4, 12'h66, 0), "R6");        // large bit level 1
    walk(52'h1000, mkva(20, 2, 3, 4, 12'h1, 0), "R8");         // fault level 1
    walk(52'h1000, mkva(1, 30, 3, 4, 12'h1, 0), "R8");         // fault level 2
    walk(52'h1000, mkva(1, 2, 40, 4, 12'h1, 0), "R8");         // fault level 3
    walk(52'h1000, mkva(1, 2, 3, 50, 12'h1, 0), "R8");         // fault level 4
    walk(52'h1000, mkva(1, 2, 3, 51, 12'h1, 0), "R8");         // bit 0 clear only

    // R10: requests during a walk are ignored
    exp_q.push_back(exp_walk(52'h1000, mkva(1, 2, 3, 4, 12'h321, 0), "R10"));
    start(52'h1000, mkva(1, 2, 3, 4, 12'h321, 0));
    for (int k = 0; k < 3; k++) begin
      chk(req_ready == 1'b0, "R10", "req_ready while busy", 64'(req_ready), 64'd0);
      req_valid = 1'b1; req_root = 52'h1000; req_va = mkva(20, 0, 0, 0, 0, 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    finish_walk();
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R10", "no extra walk", 64'(exp_q.size()), 64'd0);

    // R11: one-cycle done and held results
    walk(52'h1000, mkva(1, 2, 3, 6, 12'hEEE, 0), "R11");
    chk(done == 1'b0, "R11", "done after one cycle", 64'(done), 64'd0);
    repeat (5) @(negedge clk);
    chk(pa == last_pa, "R11", "pa held", 64'(pa), 64'(last_pa));
    chk(exec_ok == 1'b0, "R11", "exec_ok held", 64'(exec_ok), 64'd0);

    summary();
    $finish;
  end
endmodule